// File: doc/BRIEF.md
# Remotely Commanded Block-Transfer Channel

This block is a DMA-style data mover that sits on a bus slave card and is controlled by remote bus masters. A master first claims the channel through a test-and-set semaphore. Only the claiming master may then load a job: a 64-bit bus address, a 32-bit local address, a byte count, an address space, a data width, a transfer mode and a direction. When the job starts, the channel requests the backplane. While it is not requesting, it forwards the grant daisy chain unchanged. Once it owns the bus, it issues beats, either as separate single cycles or as block bursts.

At the end of a job the channel releases the bus and frees the semaphore. It then raises an interrupt at a programmed level. An interrupt-acknowledge cycle at that level returns the programmed status/ID byte. An acknowledge at any other level is passed down the acknowledge chain. If the bus signals an error during a beat, the job stops at once and the error is recorded. The interrupt is still raised in that case.

The register port is a simple word interface with a master identifier, so that the semaphore can tell requesters apart. The beat interface has three parts: an address-phase strobe, a data strobe held until acknowledge or error, and the current addresses and attributes.

Top module: `rbt_channel`

## Requirements
- R1: Eight word registers are selected by `reg_sel`. The codes are 0 control/status, 1 semaphore, 2 bus address low, 3 bus address high, 4 local address, 5 byte count, 6 mode and 7 vector. Mode holds space in bits [2:0] (0 A16, 1 A24, 2 A32, 3 A40, 4 A64), width in [6:4] (0 D8, 1 D16, 2 D32, 3 multiplexed D32, 4 D64), block mode in bit 8 and write direction in bit 9. Vector holds the status/ID byte in [7:0] and the interrupt level in [10:8]. Control reads return done in bit 0, bus error in bit 1, rejected in bit 2 and running in bit 3. Writing control bit 0 starts a job.
- R2: A semaphore read returns the busy bit in bit 0. If the channel was free, the same read sets busy and records the reader's `reg_mid` as owner. A write of 0 from the owner frees the channel. Semaphore writes from any other master are ignored.
- R3: Register writes and starts are accepted only from the owner while no job runs. All other writes leave the registers unchanged.
- R4: A start whose byte count is below 16 or above 8388608, or whose space or width code is above 4, is rejected. A rejected start sets the rejected bit and does not request the bus.
- R5: In single-cycle mode every beat has its own address phase.
- R6: In block mode a burst carries at most 256 bytes. After that a new address phase starts. Both addresses advance by the beat size.
- R7: The beat size is 1, 2, 4, 4 or 8 bytes for width codes 0 to 4. A final beat that is shorter than the beat size ends the job.
- R8: `bus_req` is high while a job waits for the bus. The first grant that arrives while requesting is kept. `bus_grant_out` follows `bus_grant_in` only while no job wants the bus. Ownership ends when the job ends.
- R9: When a job completes, done is set, the semaphore is freed and `irq_req` rises with `irq_lvl` equal to the programmed level.
- R10: An acknowledge whose level matches a pending interrupt drives `vec_oe` with the status/ID byte and clears the request. Any other acknowledge is passed on `iack_out`.
- R11: A bus error during a beat ends the job: the error bit is set, the bus is released, and the completion interrupt is still raised.
- R12: While a job runs, `m_space`, `m_width`, `m_blt` and `m_dir` show the loaded mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_mid | input | ID_W | Identifier of the accessing master |
| reg_rdata | output | 32 | Read data (combinational) |
| bus_req | output | 1 | Bus request |
| bus_grant_in | input | 1 | Grant from upstream |
| bus_grant_out | output | 1 | Grant to downstream |
| bus_own | output | 1 | Channel holds the bus |
| m_as | output | 1 | Address-phase strobe |
| m_ds | output | 1 | Data strobe, held until ack or error |
| m_addr | output | 64 | Current bus address |
| m_laddr | output | 32 | Current local address |
| m_space | output | 3 | Address space code |
| m_width | output | 3 | Data width code |
| m_blt | output | 1 | Block mode |
| m_dir | output | 1 | 1 = write to bus |
| m_ack | input | 1 | Beat acknowledge |
| m_berr | input | 1 | Beat bus error |
| irq_req | output | 1 | Interrupt pending |
| irq_lvl | output | 3 | Interrupt level |
| iack_in | input | 1 | Acknowledge chain in |
| iack_lvl | input | 3 | Level being acknowledged |
| iack_out | output | 1 | Acknowledge chain out |
| vec_oe | output | 1 | Status/ID byte driven |
| vec_data | output | 8 | Status/ID byte |

## Verification
Jobs are run in four shapes:
- a D32 single-cycle job of 16 bytes;
- a 600-byte D64 block job;
- a 20-byte D8 block job;
- a 17-byte D16 single-cycle job.

Counting address phases and beats and recording the last addresses tells apart the per-beat addressing, the 256-byte burst split and the short final beat. Separate cases cover the following:
- byte counts one step outside each end of the allowed range, and a bad width code;
- an 8-megabyte job held off by a low grant and then stopped by a bus error;
- accesses from a master that does not own the channel;
- acknowledges at the wrong level and at the right level.

// File: rtl/rbt_pkg.sv
// Shared types for the remotely commanded block-transfer channel.
// Assumes: register codes fixed as listed in the brief (R1).
package rbt_pkg;
    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_SEM   = 3'd1,
        REG_BUSLO = 3'd2,
        REG_BUSHI = 3'd3,
        REG_LOCAL = 3'd4,
        REG_LEN   = 3'd5,
        REG_MODE  = 3'd6,
        REG_VEC   = 3'd7
    } reg_e;

    typedef enum logic [2:0] {
        SEQ_IDLE, SEQ_REQ, SEQ_ADDR, SEQ_DATA, SEQ_FIN
    } seq_e;

    typedef struct packed {
        logic [63:0] bus_addr;
        logic [31:0] loc_addr;
        logic [31:0] len;
        logic [2:0]  space;
        logic [2:0]  width;
        logic        blt;
        logic        dir;
        logic [7:0]  vec;
        logic [2:0]  lvl;
    } job_t;

    // Beat size in bytes for a width code; 0 for illegal codes.
    function automatic logic [3:0] width_bytes(input logic [2:0] w);
        case (w)
            3'd0:    return 4'd1;
            3'd1:    return 4'd2;
            3'd2:    return 4'd4;
            3'd3:    return 4'd4;
            3'd4:    return 4'd8;
            default: return 4'd0;
        endcase
    endfunction
endpackage

// File: rtl/rbt_regs.sv
// Register file and ownership semaphore.
// Holds the job description, the status bits and the semaphore. Gates
// writes on ownership and checks a start request before accepting it.
// Assumes: reads are one-cycle strobes; reg_rdata is valid while reg_rd is high.
module rbt_regs
    import rbt_pkg::*;
#(
    parameter int ID_W    = 4,
    parameter int LEN_MIN = 16,
    parameter int LEN_MAX = 8388608
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      reg_sel,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [31:0]     reg_wdata,
    input  logic [ID_W-1:0] reg_mid,
    output logic [31:0]     reg_rdata,
    input  logic            running,
    input  logic            fin,
    input  logic            fin_err,
    output job_t            job,
    output logic            start
);
    logic            busy;
    logic [ID_W-1:0] owner;
    logic            st_done, st_berr, st_rej;
    logic            owner_ok, load_ok, go_req, job_ok;

    assign owner_ok = busy && (reg_mid == owner);
    assign load_ok  = owner_ok && !running;
    assign go_req   = reg_wr && (reg_sel == REG_CTRL) && reg_wdata[0] && load_ok;
    assign job_ok   = (job.len >= 32'(LEN_MIN)) && (job.len <= 32'(LEN_MAX))
                   && (job.space <= 3'd4) && (job.width <= 3'd4);
    assign start    = go_req && job_ok;

    // Semaphore: test-and-set on read, release by owner, auto-free on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            owner <= '0;
        end else if (fin) begin
            busy <= 1'b0;
        end else if (reg_rd && reg_sel == REG_SEM && !busy) begin
            busy  <= 1'b1;
            owner <= reg_mid;
        end else if (reg_wr && reg_sel == REG_SEM && owner_ok && !reg_wdata[0]) begin
            busy <= 1'b0;
        end
    end

    // Job fields: written only by the owner while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            job <= '0;
        end else if (reg_wr && load_ok) begin
            case (reg_sel)
                REG_BUSLO: job.bus_addr[31:0]  <= reg_wdata;
                REG_BUSHI: job.bus_addr[63:32] <= reg_wdata;
                REG_LOCAL: job.loc_addr        <= reg_wdata;
                REG_LEN:   job.len             <= reg_wdata;
                REG_MODE: begin
                    job.space <= reg_wdata[2:0];
                    job.width <= reg_wdata[6:4];
                    job.blt   <= reg_wdata[8];
                    job.dir   <= reg_wdata[9];
                end
                REG_VEC: begin
                    job.vec <= reg_wdata[7:0];
                    job.lvl <= reg_wdata[10:8];
                end
                default: ;
            endcase
        end
    end

    // Status bits: cleared on start, set by rejection or completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_done <= 1'b0;
            st_berr <= 1'b0;
            st_rej  <= 1'b0;
        end else if (start) begin
            st_done <= 1'b0;
            st_berr <= 1'b0;
            st_rej  <= 1'b0;
        end else if (go_req) begin
            st_rej <= 1'b1;
        end else if (fin) begin
            st_done <= 1'b1;
            st_berr <= fin_err;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (reg_sel)
            REG_CTRL:  reg_rdata = {28'b0, running, st_rej, st_berr, st_done};
            REG_SEM:   reg_rdata = {31'b0, busy};
            REG_BUSLO: reg_rdata = job.bus_addr[31:0];
            REG_BUSHI: reg_rdata = job.bus_addr[63:32];
            REG_LOCAL: reg_rdata = job.loc_addr;
            REG_LEN:   reg_rdata = job.len;
            REG_MODE:  reg_rdata = {22'b0, job.dir, job.blt, 1'b0, job.width, 1'b0, job.space};
            default:   reg_rdata = {21'b0, job.lvl, job.vec};
        endcase
    end

    a_r2_read_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == REG_SEM && !fin) |=> busy);
    a_r3_foreign_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !(busy && reg_mid == owner)) |=> $stable(job));
    a_r9_fin_frees: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !busy);
endmodule

// File: rtl/rbt_arb.sv
// Bus requester and grant daisy-chain forwarding.
// Assumes: 'want' stays high from the start of a job until its last beat.
module rbt_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic grant_in,
    output logic bus_req,
    output logic grant_out,
    output logic own
);
    assign bus_req   = want && !own;
    assign grant_out = grant_in && !want;

    // Keep the grant once taken; drop ownership when the job no longer needs the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)              own <= 1'b0;
        else if (!want)          own <= 1'b0;
        else if (bus_req && grant_in) own <= 1'b1;
    end

    a_r8_taken_only_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own) |-> $past(grant_in && bus_req));
    a_r8_release_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !want |=> !own);
endmodule

// File: rtl/rbt_seq.sv
// Job sequencer.
// Waits for the bus, then issues address phases and beats. Advances both
// addresses by the beat size, splits block transfers at BURST_MAX bytes
// and stops on completion or bus error.
// Assumes: the job fields stay stable while running (writes are blocked).
module rbt_seq
    import rbt_pkg::*;
#(
    parameter int BURST_MAX = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  job_t        job,
    input  logic        own,
    input  logic        m_ack,
    input  logic        m_berr,
    output logic        want_bus,
    output logic        running,
    output logic        fin,
    output logic        fin_err,
    output logic        m_as,
    output logic        m_ds,
    output logic [63:0] m_addr,
    output logic [31:0] m_laddr
);
    localparam int BW = $clog2(BURST_MAX) + 1;

    seq_e          state;
    logic [63:0]   cur_bus;
    logic [31:0]   cur_loc;
    logic [31:0]   remain;
    logic [BW-1:0] burst;
    logic          err_q;
    logic [3:0]    wb;
    logic [31:0]   wb32, step;
    logic          last, burst_full;

    assign wb         = width_bytes(job.width);
    assign wb32       = {28'b0, wb};
    assign step       = (remain < wb32) ? remain : wb32;
    assign last       = (remain <= wb32);
    assign burst_full = ({{(32-BW){1'b0}}, burst} + wb32) >= 32'(BURST_MAX);

    assign want_bus = (state == SEQ_REQ) || (state == SEQ_ADDR) || (state == SEQ_DATA);
    assign running  = (state != SEQ_IDLE);
    assign fin      = (state == SEQ_FIN);
    assign fin_err  = err_q;
    assign m_as     = (state == SEQ_ADDR);
    assign m_ds     = (state == SEQ_DATA);
    assign m_addr   = cur_bus;
    assign m_laddr  = cur_loc;

    // Main state machine with address, count and burst bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            cur_bus <= '0;
            cur_loc <= '0;
            remain  <= '0;
            burst   <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: if (start) begin
                    cur_bus <= job.bus_addr;
                    cur_loc <= job.loc_addr;
                    remain  <= job.len;
                    err_q   <= 1'b0;
                    state   <= SEQ_REQ;
                end
                SEQ_REQ: if (own) state <= SEQ_ADDR;
                SEQ_ADDR: begin
                    burst <= '0;
                    state <= SEQ_DATA;
                end
                SEQ_DATA: begin
                    if (m_berr) begin
                        err_q <= 1'b1;
                        state <= SEQ_FIN;
                    end else if (m_ack) begin
                        remain  <= remain - step;
                        cur_bus <= cur_bus + {60'b0, wb};
                        cur_loc <= cur_loc + wb32;
                        burst   <= burst + BW'(wb);
                        if (last)                         state <= SEQ_FIN;
                        else if (!job.blt || burst_full)  state <= SEQ_ADDR;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    a_r6_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
        {{(32-BW){1'b0}}, burst} <= 32'(BURST_MAX));
    a_r11_berr_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (m_ds && m_berr) |=> fin);
    a_r5_single_readdress: assert property (@(posedge clk) disable iff (!rst_n)
        (m_ds && m_ack && !m_berr && !job.blt && !last) |=> m_as);
endmodule

// File: rtl/rbt_irq.sv
// Completion interrupter.
// Latches the status/ID byte and level at completion and answers a
// matching acknowledge. Passes any other acknowledge down the chain.
// Assumes: the acknowledge level is valid whenever iack_in is high.
module rbt_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic [7:0] vec_in,
    input  logic [2:0] lvl_in,
    input  logic       iack_in,
    input  logic [2:0] iack_lvl,
    output logic       irq_req,
    output logic [2:0] irq_lvl,
    output logic       iack_out,
    output logic       vec_oe,
    output logic [7:0] vec_data
);
    logic       pend;
    logic [7:0] vec_q;
    logic [2:0] lvl_q;
    logic       hit;

    assign hit      = iack_in && pend && (iack_lvl == lvl_q);
    assign irq_req  = pend;
    assign irq_lvl  = lvl_q;
    assign vec_oe   = hit;
    assign vec_data = vec_q;
    assign iack_out = iack_in && !hit;

    // Pending flag: set on completion, cleared by a matching acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= 1'b0;
            vec_q <= '0;
            lvl_q <= '0;
        end else if (fire) begin
            pend  <= 1'b1;
            vec_q <= vec_in;
            lvl_q <= lvl_in;
        end else if (hit) begin
            pend <= 1'b0;
        end
    end

    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe && !fire) |=> !irq_req);
    a_r9_fire_raises: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> irq_req);
endmodule

// File: rtl/rbt_channel.sv
// Top of the remotely commanded block-transfer channel.
// Connects the register file, the requester, the sequencer and the interrupter.
// Assumes: one job at a time; the data path lives outside this block.
module rbt_channel
    import rbt_pkg::*;
#(
    parameter int ID_W      = 4,
    parameter int LEN_MIN   = 16,
    parameter int LEN_MAX   = 8388608,
    parameter int BURST_MAX = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      reg_sel,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [31:0]     reg_wdata,
    input  logic [ID_W-1:0] reg_mid,
    output logic [31:0]     reg_rdata,
    output logic            bus_req,
    input  logic            bus_grant_in,
    output logic            bus_grant_out,
    output logic            bus_own,
    output logic            m_as,
    output logic            m_ds,
    output logic [63:0]     m_addr,
    output logic [31:0]     m_laddr,
    output logic [2:0]      m_space,
    output logic [2:0]      m_width,
    output logic            m_blt,
    output logic            m_dir,
    input  logic            m_ack,
    input  logic            m_berr,
    output logic            irq_req,
    output logic [2:0]      irq_lvl,
    input  logic            iack_in,
    input  logic [2:0]      iack_lvl,
    output logic            iack_out,
    output logic            vec_oe,
    output logic [7:0]      vec_data
);
    job_t job;
    logic start, running, fin, fin_err, want_bus;

    assign m_space = job.space;
    assign m_width = job.width;
    assign m_blt   = job.blt;
    assign m_dir   = job.dir;

    rbt_regs #(.ID_W(ID_W), .LEN_MIN(LEN_MIN), .LEN_MAX(LEN_MAX)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_mid(reg_mid),
        .reg_rdata(reg_rdata), .running(running), .fin(fin),
        .fin_err(fin_err), .job(job), .start(start));

    rbt_arb u_arb (
        .clk(clk), .rst_n(rst_n), .want(want_bus), .grant_in(bus_grant_in),
        .bus_req(bus_req), .grant_out(bus_grant_out), .own(bus_own));

    rbt_seq #(.BURST_MAX(BURST_MAX)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .job(job), .own(bus_own),
        .m_ack(m_ack), .m_berr(m_berr), .want_bus(want_bus),
        .running(running), .fin(fin), .fin_err(fin_err), .m_as(m_as),
        .m_ds(m_ds), .m_addr(m_addr), .m_laddr(m_laddr));

    rbt_irq u_irq (
        .clk(clk), .rst_n(rst_n), .fire(fin), .vec_in(job.vec),
        .lvl_in(job.lvl), .iack_in(iack_in), .iack_lvl(iack_lvl),
        .irq_req(irq_req), .irq_lvl(irq_lvl), .iack_out(iack_out),
        .vec_oe(vec_oe), .vec_data(vec_data));
endmodule

// File: tb/test_rbt_channel.sv
// Directed bench for rbt_channel: one task per scenario, each checking itself.
module test_rbt_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_mid = '0;
    logic [31:0] reg_rdata;
    logic        bus_req, bus_grant_in = 1'b1, bus_grant_out, bus_own;
    logic        m_as, m_ds, m_blt, m_dir;
    logic [63:0] m_addr;
    logic [31:0] m_laddr;
    logic [2:0]  m_space, m_width;
    logic        m_ack = 1'b0, m_berr = 1'b0;
    logic        irq_req, iack_in = 1'b0, iack_out, vec_oe;
    logic [2:0]  irq_lvl, iack_lvl = '0;
    logic [7:0]  vec_data;

    int n_chk = 0, n_fail = 0;
    int as_cnt, beats, berr_at;
    logic [63:0] last_addr;
    logic [31:0] last_laddr;
    logic [2:0]  seen_space, seen_width;
    logic        seen_blt, seen_own, seen_gout;
    logic [31:0] rd;

    rbt_channel i_rbt_channel (.*);

    always #5 clk = ~clk;

    // Bus responder and monitor: acts on falling edges, away from the design's edge.
    always @(negedge clk) begin
        m_ack  = 1'b0;
        m_berr = 1'b0;
        if (rst_n) begin
            if (m_as) begin
                as_cnt++;
                seen_space = m_space; seen_width = m_width; seen_blt = m_blt;
                seen_own = bus_own; seen_gout = bus_grant_out;
            end
            if (m_ds) begin
                if (berr_at != 0 && beats + 1 == berr_at) m_berr = 1'b1;
                else begin
                    m_ack = 1'b1;
                    beats++;
                    last_addr = m_addr;
                    last_laddr = m_laddr;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] mid, input logic [2:0] sel, input logic [31:0] d);
        reg_mid = mid; reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [3:0] mid, input logic [2:0] sel, output logic [31:0] d);
        reg_mid = mid; reg_sel = sel; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic clear_mon();
        as_cnt = 0; beats = 0; berr_at = 0; last_addr = '0; last_laddr = '0;
        seen_own = 1'b0; seen_gout = 1'b1;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 5000 && !irq_req; i++) @(negedge clk);
    endtask

    task automatic load_job(input logic [3:0] mid, input logic [63:0] ba, input logic [31:0] la,
                            input logic [31:0] len, input logic [31:0] mode, input logic [31:0] vec);
        wr(mid, 3'd2, ba[31:0]);
        wr(mid, 3'd3, ba[63:32]);
        wr(mid, 3'd4, la);
        wr(mid, 3'd5, len);
        wr(mid, 3'd6, mode);
        wr(mid, 3'd7, vec);
    endtask

    task automatic ack_irq(input string tag, input logic [2:0] lvl, input logic [7:0] vec);
        iack_lvl = lvl ^ 3'd1; iack_in = 1'b1;
        #1;
        chk({tag, " R10 wrong level passes"}, iack_out, 1'b1);
        chk({tag, " R10 wrong level no vector"}, vec_oe, 1'b0);
        @(negedge clk);
        chk({tag, " R10 wrong level keeps irq"}, irq_req, 1'b1);
        iack_lvl = lvl;
        #1;
        chk({tag, " R10 match drives vector"}, {vec_oe, iack_out, vec_data}, {1'b1, 1'b0, vec});
        @(negedge clk);
        iack_in = 1'b0;
        chk({tag, " R10 irq cleared"}, irq_req, 1'b0);
    endtask

    task automatic t_reset();
        chk("R8 reset no request", {bus_req, bus_own}, 2'b00);
        chk("R8 idle grant passes", bus_grant_out, 1'b1);
        chk("R9 reset no irq", irq_req, 1'b0);
        rdreg(4'd0, 3'd0, rd);
        chk("R1 reset status", rd, 32'h0);
    endtask

    task automatic t_semaphore();
        rdreg(4'd1, 3'd1, rd);
        chk("R2 first read free", rd, 32'h0);
        rdreg(4'd2, 3'd1, rd);
        chk("R2 second read busy", rd, 32'h1);
        wr(4'd1, 3'd5, 32'h40);
        wr(4'd2, 3'd5, 32'h99);
        rdreg(4'd1, 3'd5, rd);
        chk("R3 owner write kept, foreign write ignored", rd, 32'h40);
        wr(4'd1, 3'd6, 32'h0000_0342);
        rdreg(4'd1, 3'd6, rd);
        chk("R1 mode readback", rd, 32'h0000_0342);
        wr(4'd2, 3'd1, 32'h0);
        rdreg(4'd2, 3'd1, rd);
        chk("R2 foreign release ignored", rd, 32'h1);
        wr(4'd1, 3'd1, 32'h0);
        rdreg(4'd2, 3'd1, rd);
        chk("R2 owner release frees", rd, 32'h0);
        wr(4'd2, 3'd1, 32'h0);
    endtask

    task automatic t_reject(input string tag, input logic [31:0] len, input logic [31:0] mode);
        rdreg(4'd3, 3'd1, rd);
        load_job(4'd3, 64'h1000, 32'h0, len, mode, 32'h0);
        wr(4'd3, 3'd0, 32'h1);
        repeat (4) @(negedge clk);
        chk({tag, " R4 no bus request"}, bus_req, 1'b0);
        rdreg(4'd3, 3'd0, rd);
        chk({tag, " R4 rejected flag"}, rd, 32'h4);
        wr(4'd3, 3'd1, 32'h0);
    endtask

    task automatic t_job(input string tag, input logic [31:0] len, input logic [2:0] w, input logic blt,
                         input int exp_as, input int exp_beats, input logic [31:0] last_off);
        logic [31:0] mode;
        mode = {22'b0, 1'b1, blt, 1'b0, w, 1'b0, 3'd3};
        clear_mon();
        rdreg(4'd5, 3'd1, rd);
        load_job(4'd5, 64'h0000_00AB_0000_1000, 32'h0002_0000, len, mode, 32'h0000_05C3);
        wr(4'd5, 3'd0, 32'h1);
        wait_irq();
        @(negedge clk);
        chk({tag, " R5 R6 address phases"}, as_cnt, exp_as);
        chk({tag, " R7 beat count"}, beats, exp_beats);
        chk({tag, " R6 last bus address"}, last_addr, 64'h0000_00AB_0000_1000 + last_off);
        chk({tag, " R6 last local address"}, last_laddr, 32'h0002_0000 + last_off);
        chk({tag, " R12 attributes"}, {seen_space, seen_width, seen_blt}, {3'd3, w, blt});
        chk({tag, " R8 owned, grant held"}, {seen_own, seen_gout}, 2'b10);
        chk({tag, " R9 irq level"}, {irq_req, irq_lvl}, {1'b1, 3'd5});
        rdreg(4'd0, 3'd0, rd);
        chk({tag, " R9 done status"}, rd, 32'h1);
        chk({tag, " R8 bus released"}, {bus_req, bus_own, bus_grant_out}, 3'b001);
        rdreg(4'd6, 3'd1, rd);
        chk({tag, " R9 semaphore auto-freed"}, rd, 32'h0);
        wr(4'd6, 3'd1, 32'h0);
        ack_irq(tag, 3'd5, 8'hC3);
    endtask

    task automatic t_berr();
        clear_mon();
        bus_grant_in = 1'b0;
        rdreg(4'd7, 3'd1, rd);
        load_job(4'd7, 64'h8000, 32'h0, 32'd8388608, 32'h0000_0144, 32'h0000_025A);
        wr(4'd7, 3'd0, 32'h1);
        repeat (5) @(negedge clk);
        chk("R4 R8 max length accepted, requesting", {bus_req, bus_grant_out, bus_own}, 3'b100);
        chk("R8 no cycle without grant", as_cnt, 0);
        berr_at = 3;
        bus_grant_in = 1'b1;
        wait_irq();
        @(negedge clk);
        chk("R11 beats before error", beats, 2);
        rdreg(4'd0, 3'd0, rd);
        chk("R11 error and done status", rd, 32'h3);
        chk("R11 bus released", {bus_req, bus_own}, 2'b00);
        ack_irq("R11", 3'd2, 8'h5A);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_semaphore();
        t_reject("short", 32'd15, 32'h0000_0020);
        t_reject("long", 32'h0080_0001, 32'h0000_0020);
        t_reject("badwidth", 32'd16, 32'h0000_0050);
        t_job("single D32", 32'd16, 3'd2, 1'b0, 4, 4, 32'd12);
        t_job("block D64", 32'd600, 3'd4, 1'b1, 3, 75, 32'd592);
        t_job("block D8", 32'd20, 3'd0, 1'b1, 1, 20, 32'd19);
        t_job("single D16 odd", 32'd17, 3'd1, 1'b0, 9, 9, 32'd16);
        t_berr();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule